// File: doc/BRIEF.md
# I2C Target with High-Speed Entry

This block is the bus-facing side of an I2C/SMBus target. It receives SCL and SDA as raw digital samples, brings them into the system clock domain, and finds bus events (START, repeated START, STOP, and the rising and falling clock edges). It shifts in the address byte. When the address matches its own 7-bit address, it acknowledges and then carries on as a byte-wide register target. On a write, the first data byte loads an internal register pointer, and every later byte produces a write strobe to that pointer. On a read, bytes are fetched through a read strobe starting at the pointer and shifted out MSB first, for as long as the controller keeps acknowledging. SDA is driven as an open-drain enable, where 1 pulls the line low.

The block also recognises the controller code that announces high-speed operation. This is a first byte after a START whose upper five bits are `00001`. The block leaves that byte unacknowledged and raises a mode flag that external glitch filters can use. The flag survives repeated STARTs and is cleared only by a STOP. The byte that follows the code is decoded as an ordinary address byte.

Top module: `i2c_hs_target`

## Requirements
- R1: After reset and on every STOP, SDA is released (`sdaOe`=0), `hsMode` is 0 and no register strobe fires. A START (SDA falling while SCL is high) begins a new address byte, and a transaction that follows a STOP is handled like the first one.
- R2: If `hsMode` is 0, a byte received right after a START whose bits [7:3] equal `00001` is never acknowledged: SDA stays high through its ninth clock. `hsMode` is 1 by the end of that ninth clock. The same byte pattern in any other position is treated as plain data.
- R3: After the high-speed code, the next byte (sent directly or after a repeated START) is decoded as an address byte and acknowledged when it matches.
- R4: `hsMode` stays at 1 across repeated STARTs and returns to 0 on the next STOP.
- R5: An address byte whose bits [7:1] equal `TARGET_ADDR` is acknowledged by holding SDA low for the whole high phase of the ninth clock. Bit 0 selects the direction (1 = read). Every byte received afterwards in a write is acknowledged the same way.
- R6: A non-matching address byte is not acknowledged. SDA stays released and no strobe fires until the next START or STOP.
- R7: In a write, the first byte after the address loads the pointer. Each later byte gives one `regWr` pulse with `regAddr` equal to the pointer and `regWrData` equal to the byte, and the pointer then increments.
- R8: In a read, each byte is fetched with one `regRd` pulse at `regAddr` = pointer. The pointer then increments, and the byte is sent MSB first on SDA.
- R9: A not-acknowledge from the controller after a read byte ends the read. SDA is released and no further `regRd` pulse occurs.
- R10: `sdaOe` changes only while SCL is low, and only several system clocks after the SCL falling edge.
- R11: Byte count per transfer is unbounded. The 8-bit pointer wraps from 0xFF to 0x00 and transfers continue across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the highest SCL rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sdaOe | output | 1 | Open-drain SDA enable, 1 pulls SDA low |
| hsMode | output | 1 | High-speed mode flag for external filters |
| regAddr | output | PTR_W | Register pointer used by both strobes |
| regWr | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Byte to write |
| regRd | output | 1 | One-cycle register read strobe |
| regRdData | input | 8 | Register byte, valid in the cycle of `regRd` |

## Verification
A wrong state in the control FSM appears at the ports within one SCL clock. A missed or extra bit count moves the acknowledge slot, so SDA is found high during an expected acknowledge or low during a data bit. A wrong byte-kind state turns a pointer load into a `regWr` pulse, or the reverse, and the register model shows it at once. A stale high-speed flag remains visible on `hsMode` after the STOP that should have cleared it. A pointer error is seen only at the next strobe, as the wrong `regAddr` for the write or the wrong byte returned on a read.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [4:0] HS_PREFIX = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_SKIP, ST_TX, ST_RACK, ST_IGNORE
  } ctlState_t;

  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} byteKind_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic sdaBit;
  } busEv_t;

  typedef struct packed {
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic ackOn;
    logic sdaRel;
    logic ptrLoad;
    logic wrStb;
  } dpCtl_t;
endpackage

// File: rtl/i2c_hs_dpath.sv
module i2c_hs_dpath
  import i2c_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  output busEv_t            ev,
  output logic [BYTE_W-1:0] rxByte,
  output logic [PTR_W-1:0]  ptr,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              sdaOe
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;
  logic [BYTE_W-1:0] txReg;

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  // input synchroniser plus one stage of history for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  always_comb begin
    ev.start   = sclS & sclP & sdaP & ~sdaS;
    ev.stop    = sclS & sclP & ~sdaP & sdaS;
    ev.sclRise = sclS & ~sclP;
    ev.sclFall = ~sclS & sclP;
    ev.sdaBit  = sdaS;
  end

  // receive and transmit shifters, pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      txReg  <= '0;
      ptr    <= '0;
    end else begin
      if (ctl.rxShift) rxByte <= {rxByte[BYTE_W-2:0], sdaS};
      if (ctl.txLoad) txReg <= regRdData;
      else if (ctl.txShift) txReg <= {txReg[BYTE_W-2:0], 1'b0};
      if (ctl.ptrLoad) ptr <= rxByte[PTR_W-1:0];
      else if (ctl.wrStb || ctl.txLoad) ptr <= ptr + 1'b1;
    end
  end

  // open-drain enable, only ever updated from SCL-falling decisions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdaOe <= 1'b0;
    else if (ctl.sdaRel) sdaOe <= 1'b0;
    else if (ctl.ackOn) sdaOe <= 1'b1;
    else if (ctl.txLoad) sdaOe <= ~regRdData[BYTE_W-1];
    else if (ctl.txShift) sdaOe <= ~txReg[BYTE_W-2];
  end

  // R10
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS);
endmodule

// File: rtl/i2c_hs_ctrl.sv
module i2c_hs_ctrl
  import i2c_hs_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h48
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic [BYTE_W-1:0] rxByte,
  output dpCtl_t            ctl,
  output logic              hsMode
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W);

  ctlState_t state, nState;
  byteKind_t kind, nKind;
  logic [BIT_W-1:0] bitCnt, nBit;
  logic isRead, nRead, ackSeen, nAckSeen, nHs;

  always_comb begin
    ctl = '0;
    nState = state;
    nKind = kind;
    nBit = bitCnt;
    nRead = isRead;
    nAckSeen = ackSeen;
    nHs = hsMode;
    if (ev.stop) begin
      nState = ST_IDLE;
      nHs = 1'b0;
      ctl.sdaRel = 1'b1;
    end else if (ev.start) begin
      nState = ST_RX;
      nKind = K_ADDR;
      nBit = '0;
      nRead = 1'b0;
      ctl.sdaRel = 1'b1;
    end else begin
      unique case (state)
        ST_RX: begin
          if (ev.sclRise) begin
            ctl.rxShift = 1'b1;
            nBit = bitCnt + 1'b1;
          end else if (ev.sclFall && bitCnt == LAST_BIT) begin
            nBit = '0;
            unique case (kind)
              K_ADDR: begin
                if (!hsMode && rxByte[BYTE_W-1 -: 5] == HS_PREFIX) begin
                  nHs = 1'b1;
                  nState = ST_SKIP;
                end else if (rxByte[BYTE_W-1:1] == TARGET_ADDR) begin
                  ctl.ackOn = 1'b1;
                  nState = ST_ACK;
                  nRead = rxByte[0];
                  nKind = K_PTR;
                end else begin
                  nState = ST_IGNORE;
                end
              end
              K_PTR: begin
                ctl.ackOn = 1'b1;
                ctl.ptrLoad = 1'b1;
                nState = ST_ACK;
                nKind = K_DATA;
              end
              default: begin
                ctl.ackOn = 1'b1;
                ctl.wrStb = 1'b1;
                nState = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (ev.sclFall) begin
            if (isRead) begin
              ctl.txLoad = 1'b1;
              nState = ST_TX;
              nBit = BIT_W'(1);
            end else begin
              ctl.sdaRel = 1'b1;
              nState = ST_RX;
              nBit = '0;
            end
          end
        end
        ST_SKIP: begin
          if (ev.sclFall) begin
            nState = ST_RX;
            nBit = '0;
          end
        end
        ST_TX: begin
          if (ev.sclFall) begin
            if (bitCnt == LAST_BIT) begin
              ctl.sdaRel = 1'b1;
              nState = ST_RACK;
            end else begin
              ctl.txShift = 1'b1;
              nBit = bitCnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (ev.sclRise) begin
            nAckSeen = ~ev.sdaBit;
          end else if (ev.sclFall) begin
            if (ackSeen) begin
              ctl.txLoad = 1'b1;
              nState = ST_TX;
              nBit = BIT_W'(1);
            end else begin
              nState = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kind <= K_ADDR;
      bitCnt <= '0;
      isRead <= 1'b0;
      ackSeen <= 1'b0;
      hsMode <= 1'b0;
    end else begin
      state <= nState;
      kind <= nKind;
      bitCnt <= nBit;
      isRead <= nRead;
      ackSeen <= nAckSeen;
      hsMode <= nHs;
    end
  end

  // R2
  hs_noack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP && ev.sclRise) |-> ev.sdaBit);
  // R5
  ack_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK && ev.sclRise) |-> !ev.sdaBit);
  // R4
  hs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsMode && !ev.stop) |=> hsMode);
  // R4
  hs_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ev.stop |=> !hsMode);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.txLoad, ctl.wrStb, ctl.ptrLoad}));
endmodule

// File: rtl/i2c_hs_target.sv
module i2c_hs_target
  import i2c_hs_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h48,
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  output logic             hsMode,
  output logic [PTR_W-1:0] regAddr,
  output logic             regWr,
  output logic [7:0]       regWrData,
  output logic             regRd,
  input  logic [7:0]       regRdData
);
  dpCtl_t ctl;
  busEv_t ev;
  logic [BYTE_W-1:0] rxByte;

  i2c_hs_dpath #(.SYNC_STAGES(SYNC_STAGES), .PTR_W(PTR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl), .ev(ev),
    .rxByte(rxByte), .ptr(regAddr), .regRdData(regRdData), .sdaOe(sdaOe)
  );

  i2c_hs_ctrl #(.TARGET_ADDR(TARGET_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .ctl(ctl), .hsMode(hsMode)
  );

  assign regWr = ctl.wrStb;
  assign regRd = ctl.txLoad;
  assign regWrData = rxByte;
endmodule

// File: tb/i2c_hs_target_bench.sv
module i2c_hs_target_bench;
  localparam int Q = 5;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe, hsMode, regWr, regRd;
  logic [7:0] regAddr, regWrData, regRdData;
  wire sdaLine = sdaM & ~sdaOe;
  logic [7:0] mem [256];
  int wrCnt = 0, rdCnt = 0, checks = 0, fails = 0, holdViol = 0;
  logic prevOe = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_hs_target u_i2c_hs_target (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .hsMode(hsMode), .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData),
    .regRd(regRd), .regRdData(regRdData)
  );

  assign regRdData = mem[regAddr];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      if (regWr) begin
        mem[regAddr] <= regWrData;
        wrCnt <= wrCnt + 1;
      end
      if (regRd) rdCnt <= rdCnt + 1;
    end
  end

  // R10 monitor: enable must never move while SCL is high
  always @(negedge clk) begin
    if (rstN && sdaOe !== prevOe && sclLine) holdViol++;
    prevOe = sdaOe;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclLine = 1'b1; waitC(2 * Q);
    sdaM = 1'b0; waitC(2 * Q);
    sclLine = 1'b0;
  endtask

  task automatic busRestart();
    waitC(Q); sdaM = 1'b1; waitC(Q);
    sclLine = 1'b1; waitC(2 * Q);
    sdaM = 1'b0; waitC(2 * Q);
    sclLine = 1'b0;
  endtask

  task automatic busStop();
    waitC(Q); sdaM = 1'b0; waitC(Q);
    sclLine = 1'b1; waitC(2 * Q);
    sdaM = 1'b1; waitC(2 * Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic allLow, output logic allHigh);
    for (int i = 7; i >= 0; i--) begin
      waitC(Q); sdaM = b[i]; waitC(Q);
      sclLine = 1'b1; waitC(2 * Q);
      sclLine = 1'b0;
    end
    waitC(Q); sdaM = 1'b1; waitC(Q);
    sclLine = 1'b1;
    allLow = 1'b1; allHigh = 1'b1;
    for (int k = 0; k < 2 * Q; k++) begin
      @(negedge clk);
      if (sdaLine) allLow = 1'b0; else allHigh = 1'b0;
    end
    sclLine = 1'b0;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      waitC(Q); sdaM = 1'b1; waitC(Q);
      sclLine = 1'b1; waitC(Q);
      b[i] = sdaLine; waitC(Q);
      sclLine = 1'b0;
    end
    waitC(Q); sdaM = ackIt ? 1'b0 : 1'b1; waitC(Q);
    sclLine = 1'b1; waitC(2 * Q);
    sclLine = 1'b0;
    waitC(1); sdaM = 1'b1;
  endtask

  // {address byte, pointer, data, address expected to be acknowledged}
  localparam logic [24:0] VECS [6] = '{
    {8'h90, 8'h10, 8'hA5, 1'b1},
    {8'h90, 8'h00, 8'h3C, 1'b1},
    {8'h92, 8'h20, 8'h11, 1'b0},
    {8'h90, 8'hC7, 8'h5A, 1'b1},
    {8'h10, 8'h30, 8'h77, 1'b0},
    {8'h91 ^ 8'h01 ^ 8'h80, 8'h31, 8'h66, 1'b0}
  };

  initial begin
    logic lo, hi;
    logic [7:0] rb;
    int w0, r0;
    waitC(3);
    // R1 reset state
    chk(sdaOe == 1'b0 && hsMode == 1'b0 && !regWr && !regRd, "R1 reset", {sdaOe, hsMode, regWr, regRd}, 0);
    waitC(7);
    rstN = 1'b1;
    waitC(10);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] a, p, d;
      logic expAck;
      {a, p, d, expAck} = VECS[v];
      w0 = wrCnt;
      busStart();
      sendByte(a, lo, hi);
      if (expAck) chk(lo, "R5 address ack", {lo, hi}, 2'b10);
      else chk(hi, "R6 no ack on mismatch", {lo, hi}, 2'b01);
      sendByte(p, lo, hi);
      sendByte(d, lo, hi);
      if (!expAck) chk(hi, "R6 data stays unacked", {lo, hi}, 2'b01);
      busStop();
      waitC(2);
      if (expAck) chk(mem[p] == d, "R7 write lands at pointer", mem[p], d);
      else chk(wrCnt == w0, "R6 no write strobe", wrCnt, w0);
      chk(sdaOe == 1'b0, "R1 released after STOP", sdaOe, 0);
    end

    // R2/R3/R4: high-speed code, address right after, held across repeated STARTs
    busStart();
    sendByte(8'h08, lo, hi);
    chk(hi, "R2 hs code not acked", {lo, hi}, 2'b01);
    chk(hsMode == 1'b1, "R2 hsMode set", hsMode, 1);
    sendByte(8'h90, lo, hi);
    chk(lo, "R3 address after hs code acked", {lo, hi}, 2'b10);
    sendByte(8'h40, lo, hi);
    sendByte(8'hC3, lo, hi);
    chk(lo, "R5 data byte acked", {lo, hi}, 2'b10);
    busRestart();
    chk(hsMode == 1'b1, "R4 hsMode across repeated START", hsMode, 1);
    sendByte(8'h90, lo, hi);
    sendByte(8'h40, lo, hi);
    busRestart();
    chk(hsMode == 1'b1, "R4 hsMode across second repeated START", hsMode, 1);
    sendByte(8'h91, lo, hi);
    chk(lo, "R3 read address acked in hs mode", {lo, hi}, 2'b10);
    recvByte(1'b0, rb);
    chk(rb == 8'hC3, "R8 read returns written byte", rb, 8'hC3);
    busStop();
    waitC(2);
    chk(hsMode == 1'b0, "R4 hsMode cleared by STOP", hsMode, 0);

    // R2 other code variant, then address after repeated START
    busStart();
    sendByte(8'h0F, lo, hi);
    chk(hi && hsMode, "R2 variant 0x0F", {hi, hsMode}, 2'b11);
    busRestart();
    sendByte(8'h90, lo, hi);
    chk(lo, "R3 address after Sr", {lo, hi}, 2'b10);
    busStop();
    waitC(2);
    chk(hsMode == 1'b0, "R4 cleared", hsMode, 0);

    // R2 hs pattern as a pointer byte is plain data
    busStart();
    sendByte(8'h90, lo, hi);
    sendByte(8'h08, lo, hi);
    chk(lo && !hsMode, "R2 pattern not first byte", {lo, hsMode}, 2'b10);
    busStop();

    // R11 unbounded write across pointer wrap
    w0 = wrCnt;
    busStart();
    sendByte(8'h90, lo, hi);
    sendByte(8'hFE, lo, hi);
    sendByte(8'h11, lo, hi);
    sendByte(8'h22, lo, hi);
    sendByte(8'h33, lo, hi);
    chk(lo, "R11 third data byte acked", {lo, hi}, 2'b10);
    busStop();
    waitC(2);
    chk(wrCnt == w0 + 3, "R11 write count", wrCnt, w0 + 3);
    chk(mem[8'h00] == 8'h33, "R11 wrapped write", mem[8'h00], 8'h33);

    // R8/R9 multi-byte read across wrap, ended by not-acknowledge
    busStart();
    sendByte(8'h90, lo, hi);
    sendByte(8'hFE, lo, hi);
    busRestart();
    r0 = rdCnt;
    sendByte(8'h91, lo, hi);
    recvByte(1'b1, rb);
    chk(rb == 8'h11, "R8 read byte 0", rb, 8'h11);
    recvByte(1'b1, rb);
    chk(rb == 8'h22, "R8 read byte 1", rb, 8'h22);
    recvByte(1'b0, rb);
    chk(rb == 8'h33, "R11 read across wrap", rb, 8'h33);
    waitC(Q);
    chk(sdaOe == 1'b0, "R9 released after nack", sdaOe, 0);
    busStop();
    waitC(4);
    chk(rdCnt == r0 + 3, "R9 no read after nack", rdCnt, r0 + 3);

    chk(holdViol == 0, "R10 SDA moved while SCL high", holdViol, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule